// File: doc/BRIEF.md
# Micro-op condition predicate evaluator

This block decides whether a predicated micro-operation executes. It takes a 5-bit condition selector and the current flag word. It returns a single "take" bit in the same cycle, because the block is purely combinational and holds no state.

The selector space has 32 entries split into two halves. Selectors 0 to 15 name the basic tests:

- a constant true
- the two emulation flags (emulated carry and emulated zero)
- a mixed emulation/zero test
- single architectural flags
- unsigned and signed compound comparisons

Selectors 16 to 31 return the exact complement of the selector sixteen below them. Four string-related selectors in each half have no defined meaning. For those the block raises an unsupported indication and holds the predicate low.

The flag word layout matches the flag generator upstream:

| Flag | Bit |
|------|-----|
| carry | 0 |
| parity | 2 |
| zero | 6 |
| sign | 7 |
| overflow | 11 |
| emulated carry | 12 |
| emulated zero | 13 |

No other bit of the flag word affects the result.

Top module: `cond_eval`

## Requirements
- R1: Selector 0 gives take=1 for any flag word. Selector 16 gives take=0 for any flag word.
- R2: Selector 1 returns the emulated carry flag (bit 12). Selector 2 returns the emulated zero flag (bit 13).
- R3: Selector 3 gives take=0 only when the emulated zero flag (bit 13) is clear and the zero flag (bit 6) is set. It gives take=1 otherwise.
- R4: Single-flag selectors return one flag each:

  | Selector | Flag | Bit |
  |----------|------|-----|
  | 8 | overflow | 11 |
  | 9 | carry | 0 |
  | 10 | zero | 6 |
  | 12 | sign | 7 |
  | 13 | parity | 2 |
- R5: Selector 11 returns carry OR zero, which is unsigned below-or-equal.
- R6: Selector 14 returns sign XOR overflow. Selector 15 returns (sign XOR overflow) OR zero.
- R7: For every supported selector n below 16, selector n+16 returns the logical inverse of selector n for the same flag word.
- R8: Selectors 4 to 7 and 20 to 23 drive unsupported=1 and take=0. Every other selector drives unsupported=0.
- R9: Flag bits other than 0, 2, 6, 7, 11, 12 and 13 have no effect on take or unsupported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cond_code | input | 5 | Condition selector; bit 4 inverts the test chosen by bits 3:0 |
| flags | input | FLAG_W (16) | Current flag word |
| take | output | 1 | High when the micro-operation should execute |
| unsupported | output | 1 | High when the selector names an undefined string test |

## Verification
Because the block has no state, any fault in the decode shows at the ports immediately. The fault is visible in the same evaluation as the stimulus that exposes it.

A fault in one test shows only for the selector and flag combinations that reach it. For that reason every selector is swept against every combination of the seven significant flag bits. Each sweep is repeated with the other flag bits driven to opposite levels.

An inversion fault shows as a pair of selectors sixteen apart that agree instead of differing. Each such pair is compared directly. Unsupported selectors are checked for both the error indication and a low predicate.

// File: rtl/cond_eval.sv
module cond_eval #(
  parameter int FLAG_W  = 16,
  parameter int CF_POS  = 0,
  parameter int PF_POS  = 2,
  parameter int ZF_POS  = 6,
  parameter int SF_POS  = 7,
  parameter int OF_POS  = 11,
  parameter int ECF_POS = 12,
  parameter int EZF_POS = 13
) (
  input  logic [4:0]        cond_code,
  input  logic [FLAG_W-1:0] flags,
  output logic              take,
  output logic              unsupported
);

  localparam int SEL_W = 4;

  logic cf, pf, zf, sf, ovf, ecf, ezf;
  assign cf  = flags[CF_POS];
  assign pf  = flags[PF_POS];
  assign zf  = flags[ZF_POS];
  assign sf  = flags[SF_POS];
  assign ovf = flags[OF_POS];
  assign ecf = flags[ECF_POS];
  assign ezf = flags[EZF_POS];

  logic [SEL_W-1:0] test_sel;
  logic             invert;
  logic             raw;
  logic             reserved;

  assign test_sel = cond_code[SEL_W-1:0];
  assign invert   = cond_code[SEL_W];

  always_comb begin
    raw      = 1'b0;
    reserved = 1'b0;
    case (test_sel)
      4'd0:  raw = 1'b1;
      4'd1:  raw = ecf;
      4'd2:  raw = ezf;
      4'd3:  raw = ezf | ~zf;
      4'd4, 4'd5, 4'd6, 4'd7: reserved = 1'b1;
      4'd8:  raw = ovf;
      4'd9:  raw = cf;
      4'd10: raw = zf;
      4'd11: raw = cf | zf;
      4'd12: raw = sf;
      4'd13: raw = pf;
      4'd14: raw = sf ^ ovf;
      default: raw = (sf ^ ovf) | zf;
    endcase
  end

  assign take        = ~reserved & (raw ^ invert);
  assign unsupported = reserved;

  always_comb begin
    // R8
    no_take_on_err_chk: assert (!(unsupported && take))
      else $error("take high on unsupported selector");
    // R8
    err_range_chk: assert (!unsupported || cond_code[3:2] == 2'b01)
      else $error("unsupported raised outside string selectors");
    // R1
    const_true_chk: assert (cond_code != 5'd0 || take)
      else $error("always-true selector gave low");
    // R1
    const_false_chk: assert (cond_code != 5'd16 || !take)
      else $error("always-false selector gave high");
    // R5
    unsigned_le_chk: assert (!(cond_code == 5'd11 && flags[CF_POS]) || take)
      else $error("carry set but below-or-equal not taken");
  end

endmodule

// File: tb/test_cond_eval.sv
module test_cond_eval;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  cond_code;
  logic [15:0] flags;
  logic        take, unsupported;

  cond_eval i_cond_eval (
    .cond_code(cond_code), .flags(flags),
    .take(take), .unsupported(unsupported)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam int NV = 15;
  localparam logic [22:0] VEC [NV] = '{
    {5'd0,  16'h0000, 1'b1, 1'b0},
    {5'd16, 16'hFFFF, 1'b0, 1'b0},
    {5'd1,  16'h1000, 1'b1, 1'b0},
    {5'd17, 16'h1000, 1'b0, 1'b0},
    {5'd2,  16'h2000, 1'b1, 1'b0},
    {5'd3,  16'h0040, 1'b0, 1'b0},
    {5'd3,  16'h2040, 1'b1, 1'b0},
    {5'd11, 16'h0001, 1'b1, 1'b0},
    {5'd27, 16'h0040, 1'b0, 1'b0},
    {5'd14, 16'h0800, 1'b1, 1'b0},
    {5'd15, 16'h0880, 1'b0, 1'b0},
    {5'd31, 16'h0880, 1'b1, 1'b0},
    {5'd5,  16'hFFFF, 1'b0, 1'b1},
    {5'd22, 16'h0000, 1'b0, 1'b1},
    {5'd13, 16'h0004, 1'b1, 1'b0}
  };

  function automatic string req_of(input logic [4:0] c);
    case (c[3:0])
      4'd0: return "R1";
      4'd1, 4'd2: return "R2";
      4'd3: return "R3";
      4'd4, 4'd5, 4'd6, 4'd7: return "R8";
      4'd11: return "R5";
      4'd14, 4'd15: return "R6";
      default: return "R4";
    endcase
  endfunction

  // expected per requirements R1..R8, from named flag bits
  function automatic logic exp_take(input logic [4:0] c, input logic [15:0] f);
    logic b;
    if (c[3:2] == 2'b01) return 1'b0;
    if (c[3:0] == 0) b = 1'b1;
    else if (c[3:0] == 1) b = f[12];
    else if (c[3:0] == 2) b = f[13];
    else if (c[3:0] == 3) b = !(!f[13] && f[6]);
    else if (c[3:0] == 8) b = f[11];
    else if (c[3:0] == 9) b = f[0];
    else if (c[3:0] == 10) b = f[6];
    else if (c[3:0] == 11) b = f[0] || f[6];
    else if (c[3:0] == 12) b = f[7];
    else if (c[3:0] == 13) b = f[2];
    else if (c[3:0] == 14) b = f[7] != f[11];
    else b = (f[7] != f[11]) || f[6];
    return c[4] ? !b : b;
  endfunction

  function automatic logic [15:0] spread(input logic [6:0] k);
    logic [15:0] f = '0;
    f[0] = k[0]; f[2] = k[1]; f[6] = k[2]; f[7] = k[3];
    f[11] = k[4]; f[12] = k[5]; f[13] = k[6];
    return f;
  endfunction

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s code=%0d flags=%h actual=%b expected=%b",
               req, what, cond_code, flags, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] c, input logic [15:0] f);
    @(negedge clk);
    cond_code = c;
    flags = f;
    #1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cond_code = '0;
    flags = '0;
    apply(5'd0, 16'h0000);
    check("R1", "initial", take, 1'b1);
    check("R8", "initial err", unsupported, 1'b0);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][22:18], VEC[v][17:2]);
      check(req_of(VEC[v][22:18]), "vector take", take, VEC[v][1]);
      check("R8", "vector err", unsupported, VEC[v][0]);
    end

    for (int c = 0; c < 32; c++) begin
      for (int k = 0; k < 128; k++) begin
        logic [15:0] f;
        logic t0;
        f = spread(k[6:0]);
        apply(c[4:0], f);
        check(req_of(c[4:0]), "sweep take", take, exp_take(c[4:0], f));
        check("R8", "sweep err", unsupported, c[3:2] == 2'b01);
        t0 = take;
        apply(c[4:0], f | 16'hC73A);
        check("R9", "noise high", take, t0);
        apply(c[4:0], f & ~16'hC73A);
        check("R9", "noise low", take, t0);
      end
    end

    for (int c = 0; c < 16; c++) begin
      if (c[3:2] != 2'b01) begin
        for (int k = 0; k < 128; k++) begin
          logic lo;
          apply(c[4:0], spread(k[6:0]));
          lo = take;
          apply(c[4:0] + 5'd16, spread(k[6:0]));
          check("R7", "complement pair", take, !lo);
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule